// File: doc/BRIEF.md
# Transition-to-Level Handshake Bridge

This block couples a producer that signals transfers by toggling its request line to a consumer that expects a return-to-zero request/acknowledge cycle. The producer announces a new word by flipping `prod_req` to a level different from the one last returned on `prod_ack`. The bridge latches the word into a single holding register and raises `cons_req`. It then waits for `cons_ack` to go high, releases `cons_req`, and waits for `cons_ack` to go low again. Only after that full cycle does it flip `prod_ack`, which tells the producer that the word has been delivered.

Everything runs in one clock domain. The handshake inputs are assumed to be synchronised already. The data path is one register deep, so each word goes through the whole level-signalled cycle before the producer may offer the next one. All outputs come straight from flops.

Top module: `hs_two_to_four_bridge`

## Requirements
- R1: While `rst_n` is low, `cons_req`, `prod_ack` and `cons_data` are all 0.
- R2: When the bridge is idle and sees `prod_req != prod_ack` at a clock edge with `cons_ack` low, `cons_req` is high after that edge.
- R3: The word on `prod_data` at that edge appears on `cons_data` together with the rising `cons_req`. It stays unchanged until the next accepted request.
- R4: If `cons_req` is high and `cons_ack` is high at an edge, `cons_req` is low after that edge.
- R5: If `cons_req` is high and `cons_ack` is low at an edge, `cons_req` stays high.
- R6: `prod_ack` toggles exactly once per transfer. It toggles only at an edge where `cons_req` is low and `cons_ack` has been sampled low after the consumer acknowledged.
- R7: While `prod_req == prod_ack`, `cons_req` does not rise and `cons_data` keeps its last value, whatever `prod_data` carries.
- R8: `cons_req` never rises while `cons_ack` is high. A pending request waits until the consumer's acknowledge is low.
- R9: Every word offered by the producer reaches the consumer exactly once, in the order it was offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prod_req | input | 1 | Producer request, one event per toggle |
| prod_ack | output | 1 | Producer acknowledge, one toggle per completed transfer |
| prod_data | input | DATA_W | Producer data word |
| cons_req | output | 1 | Consumer request, level signalled with return to zero |
| cons_ack | input | 1 | Consumer acknowledge, level signalled with return to zero |
| cons_data | output | DATA_W | Word held for the consumer |

## Verification
The bench builds the bridge with `DATA_W` = 12. This odd width shows any slice or width mismatch in the holding path.

Forty words are streamed. Producer gaps of zero to three cycles alternate with consumer acknowledge delays of zero to two cycles. This brings back-to-back requests, an immediate acknowledge and a slow release all within reach. During idle gaps, `prod_data` carries unrelated values.

Some transfers begin while the consumer holds a stray acknowledge high. These test the rule that the bridge waits for the acknowledge to clear before it raises its request.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

    typedef enum logic [1:0] {
        HS_IDLE    = 2'd0,
        HS_RAISE   = 2'd1,
        HS_RELEASE = 2'd2,
        HS_NOTIFY  = 2'd3
    } hs_state_e;

    typedef struct packed {
        hs_state_e st;
        logic      c_req;
        logic      p_ack;
    } hs_ctrl_t;

endpackage

// File: rtl/hsb_detect.sv
module hsb_detect (
    input  logic p_req,
    input  logic p_ack,
    output logic pending
);
    // A producer event is outstanding while the request level differs from
    // the acknowledge level last returned.
    always_comb begin
        pending = p_req ^ p_ack;
    end
endmodule

// File: rtl/hsb_hold.sv
module hsb_hold #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (load) begin
            word_d = d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign q = word_q;
endmodule

// File: rtl/hsb_ctrl.sv
module hsb_ctrl
    import hsb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic c_ack,
    output logic c_req,
    output logic p_ack,
    output logic load
);
    hs_ctrl_t r_d, r_q;

    always_comb begin
        r_d  = r_q;
        load = 1'b0;
        unique case (r_q.st)
            HS_IDLE: begin
                // start only once the consumer's acknowledge is back low
                if (pending && !c_ack) begin
                    load    = 1'b1;
                    r_d.c_req = 1'b1;
                    r_d.st    = HS_RAISE;
                end
            end
            HS_RAISE: begin
                if (c_ack) begin
                    r_d.c_req = 1'b0;
                    r_d.st    = HS_RELEASE;
                end
            end
            HS_RELEASE: begin
                if (!c_ack) begin
                    r_d.p_ack = ~r_q.p_ack;
                    r_d.st    = HS_NOTIFY;
                end
            end
            HS_NOTIFY: begin
                r_d.st = HS_IDLE;
            end
            default: r_d.st = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: HS_IDLE, c_req: 1'b0, p_ack: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign c_req = r_q.c_req;
    assign p_ack = r_q.p_ack;

    AST_START_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == HS_IDLE && pending && !c_ack) |=> c_req); // R2
    AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (c_req && c_ack) |=> !c_req); // R4
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (c_req && !c_ack) |=> c_req); // R5
    AST_ACK_AFTER_RTZ: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ack != $past(p_ack)) |-> (!c_req && !$past(c_ack))); // R6
    AST_NO_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == HS_IDLE && !pending) |=> !c_req); // R7
    AST_RISE_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_req) |-> !$past(c_ack)); // R8
endmodule

// File: rtl/hs_two_to_four_bridge.sv
module hs_two_to_four_bridge #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prod_req,
    output logic              prod_ack,
    input  logic [DATA_W-1:0] prod_data,
    output logic              cons_req,
    input  logic              cons_ack,
    output logic [DATA_W-1:0] cons_data
);
    logic pending;
    logic load;

    hsb_detect u_detect (
        .p_req   (prod_req),
        .p_ack   (prod_ack),
        .pending (pending)
    );

    hsb_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .c_ack   (cons_ack),
        .c_req   (cons_req),
        .p_ack   (prod_ack),
        .load    (load)
    );

    hsb_hold #(.DATA_W(DATA_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .d     (prod_data),
        .q     (cons_data)
    );

    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        cons_req |=> $stable(cons_data)); // R3
    AST_DATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_req == prod_ack) |=> $stable(cons_data)); // R7
endmodule

// File: tb/sim_hs_two_to_four_bridge.sv
module sim_hs_two_to_four_bridge;
    localparam int DW = 12;
    localparam int NW = 40;
    localparam int MAX_CYC = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prod_req = 1'b0;
    logic          cons_ack = 1'b0;
    logic [DW-1:0] prod_data = '0;
    logic          prod_ack;
    logic          cons_req;
    logic [DW-1:0] cons_data;

    always #10 clk = ~clk;

    hs_two_to_four_bridge #(.DATA_W(DW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .prod_req  (prod_req),
        .prod_ack  (prod_ack),
        .prod_data (prod_data),
        .cons_req  (cons_req),
        .cons_ack  (cons_ack),
        .cons_data (cons_data)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] word_of(input int i);
        return DW'((i * 37 + 5) ^ (i << 7));
    endfunction

    // behavioural reference, advanced on the inputs seen at each rising edge
    int          m_phase = 0;
    logic        m_req = 1'b0;
    logic        m_ack = 1'b0;
    logic [DW-1:0] m_data = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_req = 1'b0; m_ack = 1'b0; m_data = '0;
        end else if (m_phase == 0) begin
            if (prod_req != m_ack && !cons_ack) begin
                m_data = prod_data; m_req = 1'b1; m_phase = 1;
            end
        end else if (m_phase == 1) begin
            if (cons_ack) begin m_req = 1'b0; m_phase = 2; end
        end else if (m_phase == 2) begin
            if (!cons_ack) begin m_ack = ~m_ack; m_phase = 3; end
        end else begin
            m_phase = 0;
        end
    end

    logic [DW-1:0] sent_q[$];
    logic [DW-1:0] last_word = '0;
    logic [DW-1:0] exp_w;
    int  sent = 0, recv = 0, acks = 0, ccnt = 0, gap = 0, spur = 0;
    bit  prev_creq = 0, prev_cack = 0, prev_pack = 0, prev_eq = 1, done = 0;

    initial begin
        repeat (3) @(negedge clk);
        chk(cons_req == 1'b0, "R1 cons_req in reset", cons_req, 0);
        chk(prod_ack == 1'b0, "R1 prod_ack in reset", prod_ack, 0);
        chk(cons_data == '0, "R1 cons_data in reset", cons_data, 0);
        rst_n = 1'b1;

        for (int cyc = 0; cyc < MAX_CYC && !done; cyc++) begin
            @(negedge clk);
            chk(cons_req == m_req, "R2 cons_req vs model", cons_req, m_req);
            chk(prod_ack == m_ack, "R6 prod_ack vs model", prod_ack, m_ack);
            chk(cons_data == m_data, "R3 cons_data vs model", cons_data, m_data);
            if (prev_creq && prev_cack)
                chk(!cons_req, "R4 release after ack", cons_req, 0);
            if (prev_creq && !prev_cack)
                chk(cons_req, "R5 hold until ack", cons_req, 1);
            if (prev_eq && !prev_creq) begin
                chk(!cons_req, "R7 no request without event", cons_req, 0);
                chk(cons_data == last_word, "R7 data untouched", cons_data, last_word);
            end
            if (spur > 0 && prev_cack)
                chk(!cons_req, "R8 wait for ack low", cons_req, 0);
            if (prod_ack != prev_pack) begin
                acks++;
                chk(!cons_req && !prev_cack, "R6 toggle after rtz", cons_req, 0);
            end
            if (cons_req && !prev_creq) begin
                recv++;
                exp_w = (sent_q.size() > 0) ? sent_q.pop_front() : '0;
                chk(cons_data == exp_w, "R9 order", cons_data, exp_w);
                last_word = cons_data;
            end
            prev_creq = cons_req;
            prev_pack = prod_ack;

            // consumer side
            if (spur > 0) begin
                spur--;
                cons_ack = (spur != 0);
            end else if (cons_req && !cons_ack) begin
                if (ccnt >= recv % 3) begin cons_ack = 1'b1; ccnt = 0; end
                else ccnt++;
            end else if (!cons_req && cons_ack) begin
                if (ccnt >= recv % 2) begin cons_ack = 1'b0; ccnt = 0; end
                else ccnt++;
            end

            // producer side
            if (prod_req == prod_ack && sent < NW && spur == 0) begin
                if (gap > 0) begin
                    gap--;
                    prod_data = DW'(cyc * 91 + 3);
                end else begin
                    prod_data = word_of(sent);
                    sent_q.push_back(word_of(sent));
                    prod_req = ~prod_req;
                    sent++;
                    gap = sent % 4;
                    if (sent % 13 == 6 && !cons_ack && !cons_req) begin
                        spur = 4;
                        cons_ack = 1'b1;
                    end
                end
            end else if (prod_req == prod_ack) begin
                prod_data = DW'(cyc * 53 + 11);
            end
            prev_cack = cons_ack;
            prev_eq = (prod_req == prod_ack);
            done = (recv == NW && acks == NW && !cons_req && !cons_ack && spur == 0);
        end

        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R9 act=%0d exp=%0d", recv, NW);
        end
        chk(recv == NW, "R9 word count", recv, NW);
        chk(acks == NW, "R6 ack toggle count", acks, NW);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule